// File: doc/BRIEF.md
# Ethernet Transmit Retry Controller

This block sits between a DMA byte source and a half-duplex Ethernet MAC transmitter. Software starts a frame by pulsing `tx_go` with a byte length. The controller asks the memory side for the frame's bytes, holds them in a small byte FIFO and streams them to the MAC after a one-cycle start pulse. The MAC reports either a completed transmission (`mac_done`) or a collision (`mac_col`). After a collision the controller waits a truncated binary exponential backoff and sends the frame again from its first byte. It gives up after a fixed number of attempts.

A frame no longer than the FIFO stays in the FIFO until the frame ends, so a retry only rewinds the read pointer and reads nothing again from memory. A longer frame streams through the FIFO. A retry then flushes the FIFO and asks the memory side to start again from the buffer's first byte. When a frame ends, a status word records the attempt count and whether the frame was sent or dropped, and a transmit interrupt is raised. A status read clears both interrupts. The receive interrupt is raised only by the memory write that carries the last byte of a received frame.

Both byte streams use valid/ready. A byte moves on a cycle where valid and ready are both high. On the memory side the source holds `mem_data` while `mem_valid` is high and `mem_ready` is low. Whenever `fetch_req` is high, the source restarts at buffer byte 0. On the MAC side the controller holds `mac_data` and `mac_last` while `mac_valid` is high and `mac_ready` is low. The MAC may hold `mac_ready` low for as long as it needs.

Top module: `eth_tx_retry`

## Requirements
- R1: After reset, `tx_busy`, `mac_start`, `mac_valid`, `mem_ready`, `fetch_req`, `tx_irq`, `rx_irq`, `stat_ok` and `stat_abort` are 0 and `stat_attempts` is 0.
- R2: When idle, a `tx_go` with a nonzero `tx_len` makes `fetch_req` and `mac_start` each high for exactly one cycle, in the cycle after `tx_go`. The MAC then receives buffer bytes 0 to `tx_len`-1 in order, with `mac_last` set on the final byte only. A `tx_go` with a length of 0, or any `tx_go` while `tx_busy` is high, has no effect.
- R3: `mem_ready` is low in every cycle where `fetch_req` is high. After a fetch request, no more than `tx_len` bytes are accepted. The FIFO never holds more than DEPTH (64) bytes, so with the MAC stalled a long frame stops after exactly 64 accepted bytes.
- R4: While `mac_valid` is high and `mac_ready` is low, and no collision or completion is reported, `mac_valid` and `mac_data` stay unchanged in the next cycle.
- R5: After a collision on a frame of at most DEPTH bytes, the next attempt resends from byte 0 with no new `fetch_req`.
- R6: After a collision on a frame longer than DEPTH bytes, `fetch_req` pulses once and the next attempt resends from byte 0.
- R7: Suppose the n-th collision of a frame (n < 16) is sampled at a clock edge. The next `mac_start` then becomes high after the edge that comes 1 + k·SLOT_BITS·max(`cfg_bit_cycles`,1) edges later, where k is drawn from a free-running 16-bit LFSR and 0 ≤ k ≤ 2^min(n,10) − 1.
- R8: `mac_done` during transmission ends the frame. At the next edge `tx_irq` goes to 1, `stat_ok` to 1, `stat_abort` to 0 and `stat_attempts` to the number of `mac_start` pulses for the frame.
- R9: A 16th collision ends the frame with no further `mac_start`. At the next edge `tx_irq` goes to 1, `stat_abort` to 1, `stat_ok` to 0, `stat_attempts` to 16 and `tx_busy` to 0.
- R10: A cycle with `stat_rd` high clears `tx_irq` and `rx_irq` at the next edge, unless an event that sets that interrupt occurs in the same cycle; a setting event wins.
- R11: `rx_irq` is set only by a cycle where `rx_wr_valid` and `rx_wr_last` are both high. Non-last write beats, and `rx_wr_last` without `rx_wr_valid`, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | Start a frame (accepted only when idle) |
| tx_len | input | LENW | Frame length in bytes |
| cfg_bit_cycles | input | BCW | Clock cycles per bit time (0 treated as 1) |
| fetch_req | output | 1 | Memory source restarts from buffer byte 0 |
| mem_valid | input | 1 | Memory byte valid |
| mem_data | input | 8 | Memory byte |
| mem_ready | output | 1 | Controller accepts a memory byte |
| mac_start | output | 1 | One-cycle start of a transmit attempt |
| mac_valid | output | 1 | Byte to MAC valid |
| mac_data | output | 8 | Byte to MAC |
| mac_last | output | 1 | Current byte is the frame's last |
| mac_ready | input | 1 | MAC accepts the byte |
| mac_col | input | 1 | Collision report |
| mac_done | input | 1 | Successful transmission report |
| rx_wr_valid | input | 1 | A received-frame write beat reached memory |
| rx_wr_last | input | 1 | That beat finishes the frame |
| stat_rd | input | 1 | Status read; clears interrupts |
| tx_busy | output | 1 | A frame is in progress |
| stat_attempts | output | ATTW | Attempts used by the last finished frame |
| stat_ok | output | 1 | Last frame was sent |
| stat_abort | output | 1 | Last frame was dropped after the attempt limit |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
`fetch_req` and `mac_start` appear one cycle after `tx_go`. The interrupt and status outputs change at the edge that samples `mac_done`, a final collision, a last receive beat or `stat_rd`. The backoff gap runs from the edge that samples a collision to the edge that raises `mac_start`. The bench changes inputs just after a rising edge and samples outputs at the falling edge, so each sample sees the values the next rising edge will use. Each interrupt and status check is therefore made at the first falling edge after the edge that is expected to change it. The backoff gap is measured in falling edges between the sampled collision and the sampled start. That count must be 2 plus a whole number of slots, and the slot count must stay within the window set by the collision number.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } txr_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/txr_fifo.sv
module txr_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  input  logic          flush,
  input  logic          rewind,
  input  logic          follow,
  output logic          space,
  output logic          avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_p, rd_p, base_p;
  logic [PW-1:0] held;

  // bytes that cannot be overwritten: everything since the frame base
  assign held  = wr_p - base_p;
  assign space = held < PW'(DEPTH);
  assign avail = wr_p != rd_p;
  assign rdata = mem_q[rd_p[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p   <= '0;
      rd_p   <= '0;
      base_p <= '0;
    end else if (flush) begin
      wr_p   <= '0;
      rd_p   <= '0;
      base_p <= '0;
    end else begin
      if (push) wr_p <= wr_p + PW'(1);
      if (rewind) begin
        rd_p <= base_p;
      end else if (pop) begin
        rd_p <= rd_p + PW'(1);
        if (follow) base_p <= rd_p + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_p[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/txr_backoff.sv
module txr_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int MAX_EXP   = 10,
  parameter int ATTW      = 5,
  parameter int BCW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ATTW-1:0] col_num,
  input  logic [BCW-1:0]  bit_cycles,
  output logic            expired
);
  import txr_pkg::*;
  localparam int SBW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic [15:0]        lfsr_q;
  logic               fb;
  logic [MAX_EXP-1:0] mask;
  logic [MAX_EXP-1:0] slots_q;
  logic [BCW-1:0]     cyc_q;
  logic [SBW-1:0]     bit_q;
  logic               bit_tick, slot_tick;

  // window is 2^min(n,MAX_EXP)-1: bit g is open when g < n
  for (genvar g = 0; g < MAX_EXP; g++) begin : g_mask
    assign mask[g] = col_num > ATTW'(g);
  end

  assign fb        = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign bit_tick  = ({1'b0, cyc_q} + (BCW+1)'(1)) >= {1'b0, bit_cycles};
  assign slot_tick = bit_tick && (bit_q == SBW'(SLOT_BITS - 1));
  assign expired   = slots_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= {lfsr_q[14:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      cyc_q   <= '0;
      bit_q   <= '0;
    end else if (load) begin
      slots_q <= lfsr_q[MAX_EXP-1:0] & mask;
      cyc_q   <= '0;
      bit_q   <= '0;
    end else if (!expired) begin
      if (bit_tick) begin
        cyc_q <= '0;
        if (slot_tick) begin
          bit_q   <= '0;
          slots_q <= slots_q - MAX_EXP'(1);
        end else begin
          bit_q <= bit_q + SBW'(1);
        end
      end else begin
        cyc_q <= cyc_q + BCW'(1);
      end
    end
  end
endmodule

// File: rtl/txr_status.sv
module txr_status #(
  parameter int ATTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin_ok,
  input  logic            fin_abort,
  input  logic [ATTW-1:0] fin_attempts,
  input  logic            rx_end,
  input  logic            stat_rd,
  output logic [ATTW-1:0] stat_attempts,
  output logic            stat_ok,
  output logic            stat_abort,
  output logic            tx_irq,
  output logic            rx_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_attempts <= '0;
      stat_ok       <= 1'b0;
      stat_abort    <= 1'b0;
      tx_irq        <= 1'b0;
    end else if (fin_ok || fin_abort) begin
      stat_attempts <= fin_attempts;
      stat_ok       <= fin_ok;
      stat_abort    <= fin_abort;
      tx_irq        <= 1'b1;
    end else if (stat_rd) begin
      tx_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_irq <= 1'b0;
    else if (rx_end)  rx_irq <= 1'b1;
    else if (stat_rd) rx_irq <= 1'b0;
  end
endmodule

// File: rtl/eth_tx_retry.sv
module eth_tx_retry
  import txr_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LENW      = 11,
  parameter int MAX_ATT   = 16,
  parameter int MAX_EXP   = 10,
  parameter int SLOT_BITS = 512,
  parameter int BCW       = 8,
  localparam int ATTW     = $clog2(MAX_ATT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_go,
  input  logic [LENW-1:0] tx_len,
  input  logic [BCW-1:0]  cfg_bit_cycles,
  output logic            fetch_req,
  input  logic            mem_valid,
  input  logic [7:0]      mem_data,
  output logic            mem_ready,
  output logic            mac_start,
  output logic            mac_valid,
  output logic [7:0]      mac_data,
  output logic            mac_last,
  input  logic            mac_ready,
  input  logic            mac_col,
  input  logic            mac_done,
  input  logic            rx_wr_valid,
  input  logic            rx_wr_last,
  input  logic            stat_rd,
  output logic            tx_busy,
  output logic [ATTW-1:0] stat_attempts,
  output logic            stat_ok,
  output logic            stat_abort,
  output logic            tx_irq,
  output logic            rx_irq
);
  txr_state_e      state_q;
  logic [ATTW-1:0] att_q;
  logic [LENW-1:0] len_q, fetched_q, sent_q;
  logic            retain_q, freq_q;

  logic       f_space, f_avail, f_flush, f_rewind;
  logic [7:0] f_rdata;
  logic       go_ok, push, pop;
  logic       col_ev, done_ev, abort_ev, retry_ev, bo_expired;

  assign go_ok     = (state_q == ST_IDLE) && tx_go && (tx_len != '0);
  assign mem_ready = (state_q != ST_IDLE) && !freq_q && f_space && (fetched_q < len_q);
  assign push      = mem_valid && mem_ready;
  assign mac_valid = (state_q == ST_SEND) && f_avail && (sent_q < len_q);
  assign pop       = mac_valid && mac_ready;
  assign mac_data  = f_rdata;
  assign mac_last  = mac_valid && (sent_q == len_q - LENW'(1));
  assign mac_start = state_q == ST_START;
  assign fetch_req = freq_q;
  assign tx_busy   = state_q != ST_IDLE;

  assign col_ev   = (state_q == ST_SEND) && mac_col;
  assign done_ev  = (state_q == ST_SEND) && mac_done && !mac_col;
  assign abort_ev = col_ev && (att_q == ATTW'(MAX_ATT));
  assign retry_ev = col_ev && !abort_ev;
  assign f_flush  = go_ok || done_ev || abort_ev || (retry_ev && !retain_q);
  assign f_rewind = retry_ev && retain_q;

  txr_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .wdata  (mem_data),
    .pop    (pop),
    .rdata  (f_rdata),
    .flush  (f_flush),
    .rewind (f_rewind),
    .follow (!retain_q),
    .space  (f_space),
    .avail  (f_avail)
  );

  txr_backoff #(
    .SLOT_BITS (SLOT_BITS),
    .MAX_EXP   (MAX_EXP),
    .ATTW      (ATTW),
    .BCW       (BCW)
  ) u_backoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (retry_ev),
    .col_num    (att_q),
    .bit_cycles (cfg_bit_cycles),
    .expired    (bo_expired)
  );

  txr_status #(.ATTW(ATTW)) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .fin_ok        (done_ev),
    .fin_abort     (abort_ev),
    .fin_attempts  (att_q),
    .rx_end        (rx_wr_valid && rx_wr_last),
    .stat_rd       (stat_rd),
    .stat_attempts (stat_attempts),
    .stat_ok       (stat_ok),
    .stat_abort    (stat_abort),
    .tx_irq        (tx_irq),
    .rx_irq        (rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      att_q     <= '0;
      len_q     <= '0;
      fetched_q <= '0;
      sent_q    <= '0;
      retain_q  <= 1'b1;
      freq_q    <= 1'b0;
    end else begin
      freq_q <= go_ok || (retry_ev && !retain_q);

      if (go_ok || (retry_ev && !retain_q)) fetched_q <= '0;
      else if (push)                        fetched_q <= fetched_q + LENW'(1);

      if (go_ok || retry_ev) sent_q <= '0;
      else if (pop)          sent_q <= sent_q + LENW'(1);

      unique case (state_q)
        ST_IDLE: begin
          if (go_ok) begin
            len_q    <= tx_len;
            retain_q <= tx_len <= LENW'(DEPTH);
            att_q    <= '0;
            state_q  <= ST_START;
          end
        end
        ST_START: begin
          att_q   <= att_q + ATTW'(1);
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (done_ev || abort_ev) state_q <= ST_IDLE;
          else if (retry_ev)       state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bo_expired) state_q <= ST_START;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_tx_retry_checker.sv
module eth_tx_retry_checker #(
  parameter int ATTW    = 5,
  parameter int MAX_ATT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_busy,
  input logic            mac_start,
  input logic            mac_valid,
  input logic [7:0]      mac_data,
  input logic            mac_ready,
  input logic            mac_col,
  input logic            mac_done,
  input logic            fetch_req,
  input logic            mem_ready,
  input logic            tx_irq,
  input logic            stat_ok,
  input logic            stat_abort,
  input logic [ATTW-1:0] stat_attempts,
  input logic            stat_rd,
  input logic            rx_wr_valid,
  input logic            rx_wr_last,
  input logic            rx_irq
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> !mac_start); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!mac_valid && !mac_start && !mem_ready)); // R2

  AST_NO_FETCH_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !mem_ready); // R3

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !mac_ready && !mac_col && !mac_done) |=> (mac_valid && $stable(mac_data))); // R4

  AST_IRQ_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> (stat_ok != stat_abort)); // R8

  AST_ABORT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_abort |-> (stat_attempts == ATTW'(MAX_ATT))); // R9

  AST_IRQ_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_irq) |-> $past(stat_rd)); // R10

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_valid && rx_wr_last) |=> rx_irq); // R11

  AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_wr_valid && rx_wr_last)); // R11
endmodule

bind eth_tx_retry eth_tx_retry_checker #(.ATTW(ATTW), .MAX_ATT(MAX_ATT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_busy       (tx_busy),
  .mac_start     (mac_start),
  .mac_valid     (mac_valid),
  .mac_data      (mac_data),
  .mac_ready     (mac_ready),
  .mac_col       (mac_col),
  .mac_done      (mac_done),
  .fetch_req     (fetch_req),
  .mem_ready     (mem_ready),
  .tx_irq        (tx_irq),
  .stat_ok       (stat_ok),
  .stat_abort    (stat_abort),
  .stat_attempts (stat_attempts),
  .stat_rd       (stat_rd),
  .rx_wr_valid   (rx_wr_valid),
  .rx_wr_last    (rx_wr_last),
  .rx_irq        (rx_irq)
);

// File: tb/eth_tx_retry_test.sv
module eth_tx_retry_test;
  localparam int CLK_P = 10;
  localparam int SLOT  = 4;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_go = 1'b0;
  logic [10:0] tx_len = '0;
  logic [7:0]  cfg_bit_cycles = 8'd2;
  logic        fetch_req, mem_ready, mem_valid;
  logic [7:0]  mem_data;
  logic        mac_start, mac_valid, mac_last;
  logic [7:0]  mac_data;
  logic        mac_ready = 1'b1;
  logic        mac_col = 1'b0;
  logic        mac_done = 1'b0;
  logic        rx_wr_valid = 1'b0;
  logic        rx_wr_last = 1'b0;
  logic        stat_rd = 1'b0;
  logic        tx_busy, stat_ok, stat_abort, tx_irq, rx_irq;
  logic [4:0]  stat_attempts;

  int total = 0, bad = 0;
  int cyc = 0;
  int cur_fid = 0, cur_len = 0, src_idx = 0;
  int fetches = 0, starts = 0, ncol = 0, col_cyc = 0, att_n = 0;
  int mem_cnt = 0, xfer_sf = 0;
  int data_err = 0, r3_err = 0, r4_err = 0, bo_err = 0, bo_checks = 0;
  bit col_pend = 0, hold_pend = 0;
  logic [7:0] hold_d = '0;

  always #(CLK_P/2) clk = ~clk;

  eth_tx_retry #(.SLOT_BITS(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_len(tx_len),
    .cfg_bit_cycles(cfg_bit_cycles), .fetch_req(fetch_req),
    .mem_valid(mem_valid), .mem_data(mem_data), .mem_ready(mem_ready),
    .mac_start(mac_start), .mac_valid(mac_valid), .mac_data(mac_data),
    .mac_last(mac_last), .mac_ready(mac_ready), .mac_col(mac_col),
    .mac_done(mac_done), .rx_wr_valid(rx_wr_valid), .rx_wr_last(rx_wr_last),
    .stat_rd(stat_rd), .tx_busy(tx_busy), .stat_attempts(stat_attempts),
    .stat_ok(stat_ok), .stat_abort(stat_abort), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  function automatic logic [7:0] pat(int f, int i);
    return 8'(f * 37 + i * 7 + 3);
  endfunction

  // memory source: restarts at byte 0 on a fetch request
  assign mem_valid = 1'b1;
  assign mem_data  = pat(cur_fid, src_idx);
  always @(posedge clk) begin
    if (fetch_req) src_idx <= 0;
    else if (mem_valid && mem_ready) src_idx <= src_idx + 1;
  end

  // monitor: samples at the falling edge what the next rising edge will use
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (fetch_req) begin fetches++; mem_cnt = 0; xfer_sf = 0; end
      if (mem_valid && mem_ready) mem_cnt++;
      if (mem_cnt > cur_len) r3_err++;
      if (mem_cnt - xfer_sf > DEPTH) r3_err++;
      if (mac_start) begin
        if (col_pend) begin
          int d, unit, e;
          d = cyc - col_cyc;
          unit = SLOT * ((cfg_bit_cycles == 0) ? 1 : int'(cfg_bit_cycles));
          e = (ncol < 10) ? ncol : 10;
          bo_checks++;
          if (d < 2 || ((d - 2) % unit) != 0 || ((d - 2) / unit) > ((1 << e) - 1)) bo_err++;
        end
        col_pend = 0;
        starts++;
        att_n = 0;
      end
      if (hold_pend && !(mac_valid && mac_data == hold_d)) r4_err++;
      hold_pend = mac_valid && !mac_ready && !mac_col && !mac_done;
      hold_d = mac_data;
      if (mac_valid && mac_ready) begin
        if (mac_data != pat(cur_fid, att_n)) data_err++;
        if (mac_last != (att_n == cur_len - 1)) data_err++;
        att_n++;
        xfer_sf++;
      end
      if (mac_col && tx_busy) begin ncol++; col_cyc = cyc; col_pend = 1; end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    fetches = 0; starts = 0; ncol = 0; col_pend = 0; att_n = 0;
    data_err = 0; r3_err = 0; r4_err = 0; bo_err = 0; bo_checks = 0;
  endtask

  task automatic send_go(int fid, int len);
    @(posedge clk); #1;
    cur_fid = fid; cur_len = len;
    clear_counts();
    tx_go = 1'b1; tx_len = 11'(len);
    @(posedge clk); #1;
    tx_go = 1'b0;
  endtask

  task automatic wait_bytes(int n);
    for (int i = 0; i < 40000 && att_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_next_start(int prev);
    for (int i = 0; i < 40000 && starts == prev; i++) @(negedge clk);
  endtask

  task automatic collide_after(int n);
    wait_bytes(n);
    @(posedge clk); #1 mac_col = 1'b1;
    @(posedge clk); #1 mac_col = 1'b0;
  endtask

  task automatic finish_ok();
    @(posedge clk); #1 mac_done = 1'b1;
    @(posedge clk); #1 mac_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_status();
    @(posedge clk); #1 stat_rd = 1'b1;
    @(posedge clk); #1 stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy/start/valid", int'({tx_busy, mac_start, mac_valid}), 0);
    check("R1 mem_ready/fetch_req", int'({mem_ready, fetch_req}), 0);
    check("R1 irqs/flags", int'({tx_irq, rx_irq, stat_ok, stat_abort}), 0);
    check("R1 attempts", int'(stat_attempts), 0);
  endtask

  task automatic t_basic();
    cfg_bit_cycles = 8'd2;
    send_go(1, 10);
    wait_bytes(10);
    check("R2 bytes sent", att_n, 10);
    check("R2 byte order and last flag", data_err, 0);
    check("R2 one fetch request", fetches, 1);
    finish_ok();
    check("R8 tx_irq", int'(tx_irq), 1);
    check("R8 ok/abort flags", int'({stat_ok, stat_abort}), 2);
    check("R8 attempts", int'(stat_attempts), 1);
    check("R8 busy cleared", int'(tx_busy), 0);
    read_status();
    check("R10 read clears tx_irq", int'(tx_irq), 0);
  endtask

  task automatic t_ignore();
    clear_counts();
    @(posedge clk); #1 tx_go = 1'b1; tx_len = '0;
    @(posedge clk); #1 tx_go = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 zero length ignored busy", int'(tx_busy), 0);
    check("R2 zero length ignored start", starts, 0);
    send_go(2, 12);
    wait_bytes(4);
    @(posedge clk); #1 tx_go = 1'b1; tx_len = 11'd3;
    @(posedge clk); #1 tx_go = 1'b0;
    wait_bytes(12);
    repeat (4) @(negedge clk);
    check("R2 go while busy ignored length", att_n, 12);
    check("R2 go while busy ignored data", data_err, 0);
    check("R2 go while busy ignored starts", starts, 1);
    finish_ok();
    read_status();
  endtask

  task automatic t_backpressure();
    send_go(3, 40);
    for (int i = 0; i < 2000 && att_n < 40; i++) begin
      @(posedge clk); #1 mac_ready = 1'($urandom % 2);
    end
    @(posedge clk); #1 mac_ready = 1'b1;
    check("R4 held while stalled", r4_err, 0);
    check("R4 bytes under stall", att_n, 40);
    check("R4 data under stall", data_err, 0);
    finish_ok();
    read_status();
  endtask

  task automatic t_retain();
    cfg_bit_cycles = 8'd2;
    send_go(4, 30);
    collide_after(5);
    wait_next_start(1);
    collide_after(12);
    wait_next_start(2);
    wait_bytes(30);
    check("R5 no refetch", fetches, 1);
    check("R5 resend from byte 0", data_err, 0);
    check("R7 backoff windows", bo_err, 0);
    check("R7 backoff count", bo_checks, 2);
    finish_ok();
    check("R8 attempts after retries", int'(stat_attempts), 3);
    read_status();
  endtask

  task automatic t_stream();
    @(posedge clk); #1 mac_ready = 1'b0;
    send_go(5, 100);
    repeat (120) @(negedge clk);
    check("R3 fifo stops at depth", mem_cnt, DEPTH);
    @(posedge clk); #1 mac_ready = 1'b1;
    collide_after(70);
    wait_next_start(1);
    wait_bytes(100);
    check("R6 refetch on retry", fetches, 2);
    check("R6 resend from byte 0", data_err, 0);
    check("R3 fetch bounds", r3_err, 0);
    check("R7 backoff window long frame", bo_err, 0);
    finish_ok();
    read_status();
  endtask

  task automatic t_abort();
    cfg_bit_cycles = 8'd1;
    send_go(6, 8);
    for (int i = 1; i <= 16; i++) begin
      collide_after(1);
      if (i < 16) wait_next_start(i);
    end
    repeat (2) @(negedge clk);
    check("R9 abort flag", int'({stat_ok, stat_abort}), 1);
    check("R9 attempts at limit", int'(stat_attempts), 16);
    check("R9 tx_irq", int'(tx_irq), 1);
    check("R9 busy cleared", int'(tx_busy), 0);
    repeat (40) @(negedge clk);
    check("R9 no further start", starts, 16);
    check("R7 backoff windows to limit", bo_err, 0);
    check("R7 backoff count to limit", bo_checks, 15);
    read_status();
    cfg_bit_cycles = 8'd2;
  endtask

  task automatic t_rx();
    @(posedge clk); #1 rx_wr_valid = 1'b1; rx_wr_last = 1'b0;
    repeat (3) @(posedge clk);
    #1 rx_wr_valid = 1'b0; rx_wr_last = 1'b1;
    @(posedge clk); #1 rx_wr_last = 1'b0;
    @(negedge clk);
    check("R11 no irq before last beat", int'(rx_irq), 0);
    @(posedge clk); #1 rx_wr_valid = 1'b1; rx_wr_last = 1'b1;
    @(posedge clk); #1 rx_wr_valid = 1'b0; rx_wr_last = 1'b0;
    @(negedge clk);
    check("R11 irq on last beat", int'(rx_irq), 1);
    read_status();
    check("R10 read clears rx_irq", int'(rx_irq), 0);
    @(posedge clk); #1 rx_wr_valid = 1'b1; rx_wr_last = 1'b1; stat_rd = 1'b1;
    @(posedge clk); #1 rx_wr_valid = 1'b0; rx_wr_last = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    check("R10 set wins over read", int'(rx_irq), 1);
    read_status();
    check("R10 second read clears", int'(rx_irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ignore();
    t_backpressure();
    t_retain();
    t_stream();
    t_abort();
    t_rx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule